// File: doc/BRIEF.md
# Mailbox Lock and Handoff Controller

This block is the control core of a message mailbox that SoC agents share with one privileged controller. It keeps the ownership state, the command and length registers and the delegation registers that let a second agent (the target) work on a request. Ownership is taken by reading the lock register. The read has a side effect: when the mailbox is free it returns 0 and hands the lock to the reader. The block stores the identity of the owner and lets only the agents that the current ownership entitles change registers.

The owner gives the mailbox up by writing 0 to the execute register. That write does not free the mailbox at once. It starts a request to an external clearing sequencer and passes a bound, which is the largest length value written during the ownership period. The lock stays held until the sequencer reports completion. From that write onward, no agent can change the registers. After reset the mailbox is already held by the controller, so the controller's first job is to release it and have the storage wiped.

Each request arrives on a single-cycle access port. An external checker reports with `req_legal` whether the requester may use the mailbox at all. The controller receives three sticky interrupt bits, and the SoC side sees a level "data available" output.

Top module: `mbox_lock_ctrl`

## Requirements
- R1: After reset the mailbox is held by the controller. A LOCK read (address 0) returns 1, OWNER (address 1) reads as the `CTRL_USER` value, and all interrupts, `soc_data_avail` and `clr_valid` are low.
- R2: A legal LOCK read while the mailbox is free returns 0 in bit 0 and makes the reader the owner. OWNER then shows the reader's user, and later LOCK reads return 1 without changing the owner. Every accepted request produces `rsp_valid` on the next cycle.
- R3: A write of 0 to EXEC (address 2) by the owner or by the controller starts release. On the next cycle `clr_valid` goes high and `clr_bound` equals the largest DLEN (address 3) value written while the mailbox was held. LOCK keeps reading 1 until `clr_done` is sampled high. The mailbox is free in the cycle after that.
- R4: While clearing is in progress, register writes from the former requester are dropped.
- R5: A LOCK read by a non-controller agent while the controller holds the mailbox sets the soc-request interrupt (status bit 0).
- R6: When the SoC owner sets EXEC bit 0, the data-available interrupt (bit 1) is set. When the controller owner sets EXEC, `soc_data_avail` goes high and stays high until EXEC is cleared.
- R7: The target is the user in TGT_USER (address 5), and it acts only while TGT_VALID (address 6) bit 0 is set. The target may write DLEN, TGT_STATUS (address 7) and TGT_DONE (address 8). When it sets TGT_DONE bit 0, the target-done interrupt (bit 2) is set.
- R8: When the mailbox becomes free, TGT_USER, TGT_VALID, TGT_STATUS, TGT_DONE, EXEC and DLEN read 0.
- R9: IRQ_STAT (address 9) holds the three sticky bits. A controller write of 1 to a bit clears it, and the bits otherwise hold their value.
- R10: A request with `req_legal` low reads 0 and changes nothing. A write from an agent that is neither the owner, the target nor the controller is dropped.
- R11: CMD_STATUS (address 4), TGT_USER and TGT_VALID take writes only from the controller while the mailbox is held. An SoC owner's writes to them are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request this cycle (always accepted) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Register index |
| req_wdata | input | DATA_W | Write data |
| req_user | input | USER_W | Requester identity |
| req_ctrl | input | 1 | Requester is the privileged controller |
| req_legal | input | 1 | External checker admits this requester |
| rsp_valid | output | 1 | Response one cycle after a request |
| rsp_rdata | output | DATA_W | Read data (0 for writes and refused reads) |
| clr_valid | output | 1 | Clearing requested; held until clr_done |
| clr_bound | output | DLEN_W | Largest DLEN of the period, stable while clr_valid |
| clr_done | input | 1 | Sequencer finished; sampled only while clr_valid |
| irq_soc_req | output | 1 | Controller: SoC asked for the lock |
| irq_data_avail | output | 1 | Controller: SoC owner set EXEC |
| irq_tgt_done | output | 1 | Controller: target set TGT_DONE |
| soc_data_avail | output | 1 | SoC: controller owner set EXEC |

## Verification
A request applied before edge k updates the registers, the interrupts, `clr_valid` and `soc_data_avail` at edge k, and its response data arrives on `rsp_rdata` from the same edge. A `clr_done` sampled at edge k frees the mailbox at that edge. The bench therefore drives on the falling edge, lets one rising edge pass, and samples every result at the next falling edge. Each read-back of state made by a scenario is a separate access one cycle later. The checks cover ordering effects, such as a LOCK read during clearing and writes dropped in that window, by reading the state back through the port.

// File: rtl/mbox_lock_pkg.sv
package mbox_lock_pkg;

  typedef enum logic [1:0] {
    MB_FREE     = 2'd0,
    MB_HELD     = 2'd1,
    MB_CLEARING = 2'd2
  } mb_state_e;

  localparam int REG_IDX_W = 4;

  typedef enum logic [REG_IDX_W-1:0] {
    RA_LOCK   = 4'd0,
    RA_OWNER  = 4'd1,
    RA_EXEC   = 4'd2,
    RA_DLEN   = 4'd3,
    RA_CMD    = 4'd4,
    RA_TUSER  = 4'd5,
    RA_TVALID = 4'd6,
    RA_TSTAT  = 4'd7,
    RA_TDONE  = 4'd8,
    RA_IRQ    = 4'd9
  } reg_addr_e;

  localparam int IRQ_N       = 3;
  localparam int IRQ_SOC_REQ = 0;
  localparam int IRQ_AVAIL   = 1;
  localparam int IRQ_TDONE   = 2;

  typedef struct packed {
    logic rd;
    logic lock_rd;
    logic we_exec;
    logic we_dlen;
    logic we_cmd;
    logic we_tuser;
    logic we_tvalid;
    logic we_tstat;
    logic we_tdone;
    logic we_irq;
  } acc_s;

endpackage

// File: rtl/mbox_access_decode.sv
module mbox_access_decode
  import mbox_lock_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int USER_W = 32
) (
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [USER_W-1:0] req_user,
  input  logic              req_ctrl,
  input  logic              req_legal,
  input  mb_state_e         state,
  input  logic [USER_W-1:0] owner_user,
  input  logic              owner_ctrl,
  input  logic              tgt_valid,
  input  logic [USER_W-1:0] tgt_user,
  output acc_s              acc
);

  logic go, wr, held, own, ctl, tgt;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input reg_addr_e r);
    return a == ADDR_W'(r);
  endfunction

  always_comb begin
    go   = req_valid && req_legal;
    wr   = go && req_write;
    held = (state == MB_HELD);
    ctl  = held && req_ctrl;
    own  = held && !req_ctrl && !owner_ctrl && (req_user == owner_user);
    tgt  = held && !req_ctrl && tgt_valid && (req_user == tgt_user);

    acc           = '0;
    acc.rd        = go && !req_write;
    acc.lock_rd   = go && !req_write && hit(req_addr, RA_LOCK);
    acc.we_exec   = wr && hit(req_addr, RA_EXEC)   && (own || ctl);
    acc.we_dlen   = wr && hit(req_addr, RA_DLEN)   && (own || ctl || tgt);
    acc.we_cmd    = wr && hit(req_addr, RA_CMD)    && ctl;
    acc.we_tuser  = wr && hit(req_addr, RA_TUSER)  && ctl;
    acc.we_tvalid = wr && hit(req_addr, RA_TVALID) && ctl;
    acc.we_tstat  = wr && hit(req_addr, RA_TSTAT)  && (ctl || tgt);
    acc.we_tdone  = wr && hit(req_addr, RA_TDONE)  && (ctl || tgt);
    acc.we_irq    = wr && hit(req_addr, RA_IRQ)    && req_ctrl;
  end

endmodule

// File: rtl/mbox_lock_fsm.sv
module mbox_lock_fsm
  import mbox_lock_pkg::*;
#(
  parameter int                USER_W    = 32,
  parameter logic [USER_W-1:0] CTRL_USER = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lock_rd,
  input  logic              we_exec,
  input  logic              exec_bit,
  input  logic [USER_W-1:0] req_user,
  input  logic              req_ctrl,
  input  logic              clr_done,
  output mb_state_e         state,
  output logic [USER_W-1:0] owner_user,
  output logic              owner_ctrl,
  output logic              exec_q,
  output logic              soc_avail_q,
  output logic              evt_soc_req,
  output logic              evt_avail,
  output logic              release_done,
  output logic              clr_valid
);

  mb_state_e state_d;
  logic      grant, exec_set, exec_clr;

  always_comb begin
    grant        = lock_rd && (state == MB_FREE);
    exec_set     = we_exec && exec_bit;
    exec_clr     = we_exec && !exec_bit;
    evt_soc_req  = lock_rd && (state == MB_HELD) && owner_ctrl && !req_ctrl;
    evt_avail    = exec_set && !exec_q && !owner_ctrl;
    release_done = (state == MB_CLEARING) && clr_done;
    clr_valid    = (state == MB_CLEARING);

    state_d = state;
    unique case (state)
      MB_FREE:     if (grant)        state_d = MB_HELD;
      MB_HELD:     if (exec_clr)     state_d = MB_CLEARING;
      MB_CLEARING: if (release_done) state_d = MB_FREE;
      default:                       state_d = MB_FREE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= MB_HELD;
      owner_user  <= CTRL_USER;
      owner_ctrl  <= 1'b1;
      exec_q      <= 1'b0;
      soc_avail_q <= 1'b0;
    end else begin
      state <= state_d;
      if (grant) begin
        owner_user <= req_user;
        owner_ctrl <= req_ctrl;
      end else if (release_done) begin
        owner_user <= '0;
        owner_ctrl <= 1'b0;
      end
      if (exec_set) begin
        exec_q <= 1'b1;
        if (!exec_q && owner_ctrl) soc_avail_q <= 1'b1;
      end else if (exec_clr) begin
        exec_q      <= 1'b0;
        soc_avail_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/mbox_data_regs.sv
module mbox_data_regs #(
  parameter int DATA_W = 32,
  parameter int DLEN_W = 24,
  parameter int USER_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_dlen,
  input  logic              we_cmd,
  input  logic              we_tuser,
  input  logic              we_tvalid,
  input  logic              we_tstat,
  input  logic              we_tdone,
  input  logic [DATA_W-1:0] wdata,
  input  logic              release_done,
  output logic [DLEN_W-1:0] dlen_q,
  output logic [DLEN_W-1:0] dlen_max_q,
  output logic [DATA_W-1:0] cmd_q,
  output logic [USER_W-1:0] tuser_q,
  output logic              tvalid_q,
  output logic [DATA_W-1:0] tstat_q,
  output logic              tdone_q,
  output logic              evt_tdone
);

  logic [DLEN_W-1:0] wlen;

  always_comb begin
    wlen      = wdata[DLEN_W-1:0];
    evt_tdone = we_tdone && wdata[0] && !tdone_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dlen_q     <= '0;
      dlen_max_q <= '0;
      cmd_q      <= '0;
      tuser_q    <= '0;
      tvalid_q   <= 1'b0;
      tstat_q    <= '0;
      tdone_q    <= 1'b0;
    end else if (release_done) begin
      dlen_q     <= '0;
      dlen_max_q <= '0;
      tuser_q    <= '0;
      tvalid_q   <= 1'b0;
      tstat_q    <= '0;
      tdone_q    <= 1'b0;
    end else begin
      if (we_dlen) begin
        dlen_q <= wlen;
        if (wlen > dlen_max_q) dlen_max_q <= wlen;
      end
      if (we_cmd)    cmd_q    <= wdata;
      if (we_tuser)  tuser_q  <= wdata[USER_W-1:0];
      if (we_tvalid) tvalid_q <= wdata[0];
      if (we_tstat)  tstat_q  <= wdata;
      if (we_tdone)  tdone_q  <= wdata[0];
    end
  end

endmodule

// File: rtl/mbox_irq_status.sv
module mbox_irq_status #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic         we,
  input  logic [N-1:0] w1c,
  output logic [N-1:0] status
);

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              status[i] <= 1'b0;
      else if (set[i])         status[i] <= 1'b1;
      else if (we && w1c[i])   status[i] <= 1'b0;
    end
  end

endmodule

// File: rtl/mbox_lock_ctrl.sv
module mbox_lock_ctrl
  import mbox_lock_pkg::*;
#(
  parameter int                ADDR_W    = 4,
  parameter int                DATA_W    = 32,
  parameter int                USER_W    = 32,
  parameter int                DLEN_W    = 24,
  parameter logic [USER_W-1:0] CTRL_USER = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [USER_W-1:0] req_user,
  input  logic              req_ctrl,
  input  logic              req_legal,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              clr_valid,
  output logic [DLEN_W-1:0] clr_bound,
  input  logic              clr_done,
  output logic              irq_soc_req,
  output logic              irq_data_avail,
  output logic              irq_tgt_done,
  output logic              soc_data_avail
);

  acc_s              acc;
  mb_state_e         state;
  logic [USER_W-1:0] owner_user, tuser_q;
  logic              owner_ctrl, exec_q, soc_avail_q, tvalid_q, tdone_q;
  logic              evt_soc_req, evt_avail, evt_tdone, release_done;
  logic [DLEN_W-1:0] dlen_q, dlen_max_q;
  logic [DATA_W-1:0] cmd_q, tstat_q, rd_mux;
  logic [IRQ_N-1:0]  irq_set, irq_q;

  mbox_access_decode #(.ADDR_W(ADDR_W), .USER_W(USER_W)) u_dec (
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_user  (req_user),
    .req_ctrl  (req_ctrl),
    .req_legal (req_legal),
    .state     (state),
    .owner_user(owner_user),
    .owner_ctrl(owner_ctrl),
    .tgt_valid (tvalid_q),
    .tgt_user  (tuser_q),
    .acc       (acc)
  );

  mbox_lock_fsm #(.USER_W(USER_W), .CTRL_USER(CTRL_USER)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .lock_rd     (acc.lock_rd),
    .we_exec     (acc.we_exec),
    .exec_bit    (req_wdata[0]),
    .req_user    (req_user),
    .req_ctrl    (req_ctrl),
    .clr_done    (clr_done),
    .state       (state),
    .owner_user  (owner_user),
    .owner_ctrl  (owner_ctrl),
    .exec_q      (exec_q),
    .soc_avail_q (soc_avail_q),
    .evt_soc_req (evt_soc_req),
    .evt_avail   (evt_avail),
    .release_done(release_done),
    .clr_valid   (clr_valid)
  );

  mbox_data_regs #(.DATA_W(DATA_W), .DLEN_W(DLEN_W), .USER_W(USER_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .we_dlen     (acc.we_dlen),
    .we_cmd      (acc.we_cmd),
    .we_tuser    (acc.we_tuser),
    .we_tvalid   (acc.we_tvalid),
    .we_tstat    (acc.we_tstat),
    .we_tdone    (acc.we_tdone),
    .wdata       (req_wdata),
    .release_done(release_done),
    .dlen_q      (dlen_q),
    .dlen_max_q  (dlen_max_q),
    .cmd_q       (cmd_q),
    .tuser_q     (tuser_q),
    .tvalid_q    (tvalid_q),
    .tstat_q     (tstat_q),
    .tdone_q     (tdone_q),
    .evt_tdone   (evt_tdone)
  );

  always_comb begin
    irq_set              = '0;
    irq_set[IRQ_SOC_REQ] = evt_soc_req;
    irq_set[IRQ_AVAIL]   = evt_avail;
    irq_set[IRQ_TDONE]   = evt_tdone;
  end

  mbox_irq_status #(.N(IRQ_N)) u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (irq_set),
    .we    (acc.we_irq),
    .w1c   (req_wdata[IRQ_N-1:0]),
    .status(irq_q)
  );

  always_comb begin
    rd_mux = '0;
    if (acc.rd) begin
      unique case (req_addr)
        ADDR_W'(RA_LOCK):   rd_mux = DATA_W'(state != MB_FREE);
        ADDR_W'(RA_OWNER):  rd_mux = DATA_W'(owner_user);
        ADDR_W'(RA_EXEC):   rd_mux = DATA_W'(exec_q);
        ADDR_W'(RA_DLEN):   rd_mux = DATA_W'(dlen_q);
        ADDR_W'(RA_CMD):    rd_mux = cmd_q;
        ADDR_W'(RA_TUSER):  rd_mux = DATA_W'(tuser_q);
        ADDR_W'(RA_TVALID): rd_mux = DATA_W'(tvalid_q);
        ADDR_W'(RA_TSTAT):  rd_mux = tstat_q;
        ADDR_W'(RA_TDONE):  rd_mux = DATA_W'(tdone_q);
        ADDR_W'(RA_IRQ):    rd_mux = DATA_W'(irq_q);
        default:            rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_rdata <= rd_mux;
    end
  end

  assign clr_bound      = dlen_max_q;
  assign irq_soc_req    = irq_q[IRQ_SOC_REQ];
  assign irq_data_avail = irq_q[IRQ_AVAIL];
  assign irq_tgt_done   = irq_q[IRQ_TDONE];
  assign soc_data_avail = soc_avail_q;

endmodule

// File: rtl/mbox_lock_ctrl_sva.sv
module mbox_lock_ctrl_sva
  import mbox_lock_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int DLEN_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DATA_W-1:0] req_wdata,
  input logic              req_ctrl,
  input logic              req_legal,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              clr_valid,
  input logic [DLEN_W-1:0] clr_bound,
  input logic              clr_done,
  input logic              irq_soc_req,
  input logic              irq_tgt_done,
  input logic              soc_data_avail
);

  logic w1c_hit;
  assign w1c_hit = req_valid && req_write && req_legal && req_ctrl &&
                   (req_addr == ADDR_W'(RA_IRQ));

  AST_CLR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    clr_valid && !clr_done |=> clr_valid); // R3
  AST_CLR_BOUND_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    clr_valid && !clr_done |=> $stable(clr_bound)); // R3
  AST_CLR_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    clr_valid && clr_done |=> !clr_valid); // R3
  AST_AVAIL_OFF_CLEARING: assert property (@(posedge clk) disable iff (!rst_n)
    clr_valid |-> !soc_data_avail); // R6
  AST_RESP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R2
  AST_REFUSED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_legal |=> rsp_rdata == '0); // R10
  AST_SOCREQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    irq_soc_req && !(w1c_hit && req_wdata[IRQ_SOC_REQ]) |=> irq_soc_req); // R9
  AST_TDONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    irq_tgt_done && !(w1c_hit && req_wdata[IRQ_TDONE]) |=> irq_tgt_done); // R9

endmodule

bind mbox_lock_ctrl mbox_lock_ctrl_sva #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DLEN_W(DLEN_W)
) u_sva (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_write     (req_write),
  .req_addr      (req_addr),
  .req_wdata     (req_wdata),
  .req_ctrl      (req_ctrl),
  .req_legal     (req_legal),
  .rsp_valid     (rsp_valid),
  .rsp_rdata     (rsp_rdata),
  .clr_valid     (clr_valid),
  .clr_bound     (clr_bound),
  .clr_done      (clr_done),
  .irq_soc_req   (irq_soc_req),
  .irq_tgt_done  (irq_tgt_done),
  .soc_data_avail(soc_data_avail)
);

// File: tb/mbox_lock_ctrl_tb_top.sv
module mbox_lock_ctrl_tb_top;

  localparam logic [31:0] CTRL  = 32'hFFFF_FFFF;
  localparam logic [31:0] SOC_A = 32'h1111_1111;
  localparam logic [31:0] SOC_B = 32'h2222_2222;

  localparam logic [3:0] A_LOCK = 4'd0, A_OWNER = 4'd1, A_EXEC = 4'd2, A_DLEN = 4'd3,
                         A_CMD = 4'd4, A_TUSER = 4'd5, A_TVALID = 4'd6, A_TSTAT = 4'd7,
                         A_TDONE = 4'd8, A_IRQ = 4'd9;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_ctrl = 1'b0, req_legal = 1'b0;
  logic [3:0]  req_addr = '0;
  logic [31:0] req_wdata = '0, req_user = '0;
  logic        rsp_valid, clr_valid, irq_soc_req, irq_data_avail, irq_tgt_done, soc_data_avail;
  logic [31:0] rsp_rdata;
  logic [23:0] clr_bound;
  logic        clr_done = 1'b0;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  mbox_lock_ctrl dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_user(req_user), .req_ctrl(req_ctrl), .req_legal(req_legal),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .clr_valid(clr_valid), .clr_bound(clr_bound), .clr_done(clr_done),
    .irq_soc_req(irq_soc_req), .irq_data_avail(irq_data_avail),
    .irq_tgt_done(irq_tgt_done), .soc_data_avail(soc_data_avail)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic wr, input logic [3:0] a, input logic [31:0] d,
                     input logic [31:0] u, input logic c, input logic lg,
                     output logic [31:0] rd);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    req_user = u; req_ctrl = c; req_legal = lg;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; req_legal = 1'b0; req_ctrl = 1'b0;
    rd = rsp_rdata;
    if (!rsp_valid) check("R2 rsp_valid", {31'd0, rsp_valid}, 32'd1);
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [31:0] d, input logic [31:0] u, input logic c);
    logic [31:0] dummy;
    acc(1'b1, a, d, u, c, 1'b1, dummy);
  endtask

  task automatic rd_chk(input string tag, input logic [3:0] a, input logic [31:0] u,
                        input logic c, input logic [31:0] exp);
    logic [31:0] v;
    acc(1'b0, a, 32'd0, u, c, 1'b1, v);
    check(tag, v, exp);
  endtask

  task automatic pulse_done();
    @(negedge clk);
    clr_done = 1'b1;
    @(negedge clk);
    clr_done = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 irq_soc_req", {31'd0, irq_soc_req}, 32'd0);
    check("R1 irq_data_avail", {31'd0, irq_data_avail}, 32'd0);
    check("R1 irq_tgt_done", {31'd0, irq_tgt_done}, 32'd0);
    check("R1 soc_data_avail", {31'd0, soc_data_avail}, 32'd0);
    check("R1 clr_valid", {31'd0, clr_valid}, 32'd0);
    rd_chk("R1 owner is controller", A_OWNER, SOC_A, 1'b0, CTRL);
    rd_chk("R1 lock held", A_LOCK, SOC_A, 1'b0, 32'd1);
    check("R5 soc request irq", {31'd0, irq_soc_req}, 32'd1);
    wr_reg(A_IRQ, 32'd1, CTRL, 1'b1);
    check("R9 w1c soc_req", {31'd0, irq_soc_req}, 32'd0);
  endtask

  task automatic t_initial_release();
    wr_reg(A_DLEN, 32'd40, CTRL, 1'b1);
    wr_reg(A_DLEN, 32'd16, CTRL, 1'b1);
    wr_reg(A_EXEC, 32'd0, CTRL, 1'b1);
    check("R3 clr_valid", {31'd0, clr_valid}, 32'd1);
    check("R3 clr_bound max", {8'd0, clr_bound}, 32'd40);
    rd_chk("R3 lock held while clearing", A_LOCK, SOC_A, 1'b0, 32'd1);
    check("R3 clr_valid held", {31'd0, clr_valid}, 32'd1);
    pulse_done();
    check("R3 clr_valid drops", {31'd0, clr_valid}, 32'd0);
    rd_chk("R2 free lock read", A_LOCK, SOC_A, 1'b0, 32'd0);
    rd_chk("R2 owner recorded", A_OWNER, SOC_B, 1'b0, SOC_A);
    rd_chk("R2 second lock read", A_LOCK, SOC_B, 1'b0, 32'd1);
    rd_chk("R2 owner unchanged", A_OWNER, SOC_B, 1'b0, SOC_A);
    rd_chk("R8 dlen zero after free", A_DLEN, SOC_A, 1'b0, 32'd0);
  endtask

  task automatic t_soc_flow();
    logic [31:0] v;
    wr_reg(A_DLEN, 32'd99, SOC_B, 1'b0);
    rd_chk("R10 non-owner write dropped", A_DLEN, SOC_A, 1'b0, 32'd0);
    acc(1'b0, A_OWNER, 32'd0, SOC_A, 1'b0, 1'b0, v);
    check("R10 refused read zero", v, 32'd0);
    acc(1'b1, A_DLEN, 32'd77, SOC_A, 1'b0, 1'b0, v);
    rd_chk("R10 refused write dropped", A_DLEN, SOC_A, 1'b0, 32'd0);
    wr_reg(A_CMD, 32'd5, SOC_A, 1'b0);
    rd_chk("R11 cmd by soc dropped", A_CMD, SOC_A, 1'b0, 32'd0);
    wr_reg(A_TVALID, 32'd1, SOC_A, 1'b0);
    rd_chk("R11 tvalid by soc dropped", A_TVALID, SOC_A, 1'b0, 32'd0);
    wr_reg(A_DLEN, 32'd8, SOC_A, 1'b0);
    wr_reg(A_EXEC, 32'd1, SOC_A, 1'b0);
    check("R6 irq_data_avail", {31'd0, irq_data_avail}, 32'd1);
    check("R6 soc_data_avail low", {31'd0, soc_data_avail}, 32'd0);
    wr_reg(A_TSTAT, 32'd7, SOC_B, 1'b0);
    rd_chk("R7 not target yet", A_TSTAT, SOC_A, 1'b0, 32'd0);
    wr_reg(A_TUSER, SOC_B, CTRL, 1'b1);
    wr_reg(A_TVALID, 32'd1, CTRL, 1'b1);
    wr_reg(A_TSTAT, 32'd7, SOC_B, 1'b0);
    rd_chk("R7 target status", A_TSTAT, SOC_A, 1'b0, 32'd7);
    wr_reg(A_DLEN, 32'd64, SOC_B, 1'b0);
    check("R7 tgt_done not yet", {31'd0, irq_tgt_done}, 32'd0);
    wr_reg(A_TDONE, 32'd1, SOC_B, 1'b0);
    check("R7 irq_tgt_done", {31'd0, irq_tgt_done}, 32'd1);
    wr_reg(A_CMD, 32'd3, CTRL, 1'b1);
    rd_chk("R11 cmd by controller", A_CMD, SOC_A, 1'b0, 32'd3);
    wr_reg(A_EXEC, 32'd0, SOC_A, 1'b0);
    check("R3 clr_valid soc release", {31'd0, clr_valid}, 32'd1);
    check("R3 bound from target dlen", {8'd0, clr_bound}, 32'd64);
    wr_reg(A_DLEN, 32'd5, SOC_A, 1'b0);
    rd_chk("R4 write dropped while clearing", A_DLEN, SOC_A, 1'b0, 32'd64);
    wr_reg(A_TSTAT, 32'd9, SOC_B, 1'b0);
    rd_chk("R4 target locked out while clearing", A_TSTAT, SOC_A, 1'b0, 32'd7);
    pulse_done();
    rd_chk("R8 tuser cleared", A_TUSER, SOC_A, 1'b0, 32'd0);
    rd_chk("R8 tvalid cleared", A_TVALID, SOC_A, 1'b0, 32'd0);
    rd_chk("R8 tstat cleared", A_TSTAT, SOC_A, 1'b0, 32'd0);
    rd_chk("R8 tdone cleared", A_TDONE, SOC_A, 1'b0, 32'd0);
    rd_chk("R8 exec cleared", A_EXEC, SOC_A, 1'b0, 32'd0);
    rd_chk("R9 sticky bits", A_IRQ, CTRL, 1'b1, 32'd6);
    wr_reg(A_IRQ, 32'd2, SOC_A, 1'b0);
    rd_chk("R9 soc w1c ignored", A_IRQ, CTRL, 1'b1, 32'd6);
    wr_reg(A_IRQ, 32'd6, CTRL, 1'b1);
    rd_chk("R9 w1c cleared", A_IRQ, CTRL, 1'b1, 32'd0);
  endtask

  task automatic t_ctrl_flow();
    rd_chk("R2 controller lock read", A_LOCK, CTRL, 1'b1, 32'd0);
    wr_reg(A_EXEC, 32'd1, CTRL, 1'b1);
    check("R6 soc_data_avail high", {31'd0, soc_data_avail}, 32'd1);
    check("R6 no controller irq", {31'd0, irq_data_avail}, 32'd0);
    rd_chk("R6 exec reads 1", A_EXEC, SOC_A, 1'b0, 32'd1);
    check("R6 soc_data_avail level", {31'd0, soc_data_avail}, 32'd1);
    wr_reg(A_EXEC, 32'd0, CTRL, 1'b1);
    check("R6 soc_data_avail drops", {31'd0, soc_data_avail}, 32'd0);
    check("R3 clr_valid ctrl release", {31'd0, clr_valid}, 32'd1);
    check("R3 bound zero", {8'd0, clr_bound}, 32'd0);
    pulse_done();
    rd_chk("R3 free after done", A_LOCK, SOC_B, 1'b0, 32'd0);
  endtask

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_initial_release();
    t_soc_flow();
    wr_reg(A_EXEC, 32'd0, SOC_A, 1'b0);
    pulse_done();
    t_ctrl_flow();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule